// File: doc/BRIEF.md
# Hot-Spot Data Bank Controller

This block keeps the mapping state for eight data-banking zones. Each zone owns a 16-bit bank base address and a one-bit mode (ROM or RAM). Software changes a zone by touching a hot-spot: an access whose low twelve address bits encode both the operation and its operand. Some operations load a byte of the base. Some add to it or subtract from it. Others map the zone onto a RAM or ROM page, or set its mode. A 3-bit zone index, supplied by the surrounding logic, picks which zone the hot-spot acts on.

An ordinary access to the 2 KiB data window is translated through the zone chosen by the same index. The physical address is the zone base plus the window offset. In RAM mode the block decides read or write from the opcode byte that was captured for the current instruction, since there is no write strobe. Any touch of an undefined hot-spot offset raises a sticky forbidden flag. So does a store-class opcode aimed at a ROM-mode window.

Bus addresses are the 13-bit physical bus. Bit 12 clear with an offset of $200 or more is the hot-spot space. `acc_addr[12:11] = 2'b10` is the data window. Every other address, such as the $000-$1FF page and the $1800-$1FFF code area, is ignored.

Top module: `hsb_ctrl`

## Requirements
- R1: After reset every zone has base $0000 and mode ROM, and `forbidden` is low.
- R2: Hot-spot offset $4xx writes the low byte of the selected zone's base with address bits 7:0. Offset $5xx writes the high byte. The other byte keeps its value.
- R3: Hot-spot offset $600 or $601 sets the selected zone's mode to address bit 0, where 0 is ROM and 1 is RAM.
- R4: Offset $700-$71F sets the base to (bits 4:0)×$100 and the mode to RAM. Offset $900-$97F sets the base to (bits 6:0)×$100 and the mode to ROM.
- R5: Offset $Cxx adds bits 7:0 to the base and $Dxx subtracts them, both modulo 2^16.
- R6: Offset $E00-$E1F adds (bits 4:0)×$100 to the base and $E40-$E5F subtracts it, both modulo 2^16.
- R7: For a data-window access `win_hit` is high. `win_phys` then equals the selected zone's base plus `acc_addr[10:0]`, modulo 2^16.
- R8: `win_write` is high only for a window access to a RAM-mode zone whose opcode byte lies in $80-$9F. Otherwise the access is a read.
- R9: A window access to a ROM-mode zone with an opcode in $80-$9F sets `forbidden`.
- R10: Any hot-spot offset in $200-$FFF outside the defined ranges sets `forbidden`. Offsets $280-$2FF and $880-$8FF, addresses below $200, and the $1800-$1FFF area leave all state unchanged.
- R11: Once set, `forbidden` stays high until reset. State changes take effect on the next cycle.
- R12: A hot-spot changes only the zone named by `zone_sel`. Every other zone keeps its base and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A bus access is present this cycle |
| acc_addr | input | 13 | Physical bus address of the access |
| zone_sel | input | 3 | Zone the access refers to |
| opcode | input | 8 | Captured opcode byte of the current instruction |
| win_hit | output | 1 | The access targets the data window |
| win_phys | output | 16 | Translated physical address |
| win_write | output | 1 | Window access is a write |
| forbidden | output | 1 | Sticky forbidden-access flag |

## Verification
A corrupt base register in any zone shows up at `win_phys` on the first window access through that zone after the damaging hot-spot. A lost mode bit shows up at `win_write`, or as a spurious `forbidden`, in the same cycle as that access. Writes to the wrong zone are exposed by probing untouched zones. A wrong wrap appears as a wrong address when the base is driven across $FFFF or $0000. Decode faults in the hot-spot ranges appear one cycle later on `forbidden`, or as an unchanged base.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

   typedef enum logic [3:0] {
      HS_NONE,
      HS_SETLO,
      HS_SETHI,
      HS_MODE,
      HS_MAPRAM,
      HS_MAPROM,
      HS_ADDB,
      HS_SUBB,
      HS_ADDP,
      HS_SUBP,
      HS_BAD
   } hs_op_e;

   typedef enum logic {
      ZM_ROM = 1'b0,
      ZM_RAM = 1'b1
   } zmode_e;

endpackage

// File: rtl/hsb_decode.sv
module hsb_decode
   import hsb_pkg::*;
#(
   parameter int OFF_W = 12
) (
   input  logic             hs_valid,
   input  logic [OFF_W-1:0] offset,
   output hs_op_e           op
);
   localparam int SEL_LSB = OFF_W - 4;

   initial begin
      if (OFF_W != 12) $error("hsb_decode: OFF_W must be 12");
   end

   logic [3:0] page;
   assign page = offset[OFF_W-1:SEL_LSB];

   always_comb begin
      op = HS_NONE;
      if (hs_valid) begin
         case (page)
            4'h0, 4'h1: op = HS_NONE;
            4'h2:       op = offset[7] ? HS_NONE : HS_BAD;
            4'h4:       op = HS_SETLO;
            4'h5:       op = HS_SETHI;
            4'h6:       op = (offset[7:1] == 7'd0) ? HS_MODE : HS_BAD;
            4'h7:       op = (offset[7:5] == 3'd0) ? HS_MAPRAM : HS_BAD;
            4'h8:       op = offset[7] ? HS_NONE : HS_BAD;
            4'h9:       op = offset[7] ? HS_BAD : HS_MAPROM;
            4'hC:       op = HS_ADDB;
            4'hD:       op = HS_SUBB;
            4'hE: begin
               case (offset[7:5])
                  3'd0:    op = HS_ADDP;
                  3'd2:    op = HS_SUBP;
                  default: op = HS_BAD;
               endcase
            end
            default:    op = HS_BAD;
         endcase
      end
   end
endmodule

// File: rtl/hsb_zone_file.sv
module hsb_zone_file
   import hsb_pkg::*;
#(
   parameter int ZONES  = 8,
   parameter int BANK_W = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  hs_op_e                    op,
   input  logic [7:0]                operand,
   input  logic [$clog2(ZONES)-1:0]  zsel,
   output logic [ZONES*BANK_W-1:0]   bank_flat,
   output logic [ZONES-1:0]          mode_vec
);
   localparam int ZSEL_W = $clog2(ZONES);
   localparam int PAGE_SH = 8;

   initial begin
      if (BANK_W < 16) $error("hsb_zone_file: BANK_W must be at least 16");
      if (ZONES < 2)   $error("hsb_zone_file: need two or more zones");
   end

   logic [BANK_W-1:0] sel_bank;
   logic [BANK_W-1:0] nxt_bank;
   logic              nxt_mode;
   logic              upd;
   logic [BANK_W-1:0] byte_amt;
   logic [BANK_W-1:0] page_amt;

   assign sel_bank = bank_flat[zsel*BANK_W +: BANK_W];
   assign byte_amt = BANK_W'(operand);
   assign page_amt = BANK_W'(operand[4:0]) << PAGE_SH;

   always_comb begin
      nxt_bank = sel_bank;
      nxt_mode = mode_vec[zsel];
      upd      = 1'b1;
      case (op)
         HS_SETLO:  nxt_bank[7:0]  = operand;
         HS_SETHI:  nxt_bank[15:8] = operand;
         HS_MODE:   nxt_mode = operand[0];
         HS_MAPRAM: begin
            nxt_bank = BANK_W'(operand[4:0]) << PAGE_SH;
            nxt_mode = ZM_RAM;
         end
         HS_MAPROM: begin
            nxt_bank = BANK_W'(operand[6:0]) << PAGE_SH;
            nxt_mode = ZM_ROM;
         end
         HS_ADDB:   nxt_bank = sel_bank + byte_amt;
         HS_SUBB:   nxt_bank = sel_bank - byte_amt;
         HS_ADDP:   nxt_bank = sel_bank + page_amt;
         HS_SUBP:   nxt_bank = sel_bank - page_amt;
         default:   upd = 1'b0;
      endcase
   end

   for (genvar g = 0; g < ZONES; g++) begin : g_zone
      logic [BANK_W-1:0] bank_q;
      logic              mode_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            bank_q <= '0;
            mode_q <= ZM_ROM;
         end else if (upd && (zsel == ZSEL_W'(g))) begin
            bank_q <= nxt_bank;
            mode_q <= nxt_mode;
         end
      end
      assign bank_flat[g*BANK_W +: BANK_W] = bank_q;
      assign mode_vec[g] = mode_q;
   end
endmodule

// File: rtl/hsb_window.sv
module hsb_window
   import hsb_pkg::*;
#(
   parameter int ZONES  = 8,
   parameter int BANK_W = 16,
   parameter int WIN_W  = 11
) (
   input  logic                      win_valid,
   input  logic [ZONES*BANK_W-1:0]   bank_flat,
   input  logic [ZONES-1:0]          mode_vec,
   input  logic [$clog2(ZONES)-1:0]  zsel,
   input  logic [WIN_W-1:0]          offset,
   input  logic [7:0]                opcode,
   output logic [BANK_W-1:0]         phys,
   output logic                      is_write,
   output logic                      rom_store
);
   initial begin
      if (WIN_W > BANK_W) $error("hsb_window: window wider than bank address");
   end

   logic store_op;
   logic zone_ram;

   assign store_op  = (opcode[7:5] == 3'b100);
   assign zone_ram  = (mode_vec[zsel] == ZM_RAM);
   assign phys      = bank_flat[zsel*BANK_W +: BANK_W] + BANK_W'(offset);
   assign is_write  = win_valid && zone_ram && store_op;
   assign rom_store = win_valid && !zone_ram && store_op;
endmodule

// File: rtl/hsb_ctrl.sv
module hsb_ctrl
   import hsb_pkg::*;
#(
   parameter int ZONES  = 8,
   parameter int BANK_W = 16,
   parameter int BUS_W  = 13,
   parameter int WIN_W  = 11
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      acc_valid,
   input  logic [BUS_W-1:0]          acc_addr,
   input  logic [$clog2(ZONES)-1:0]  zone_sel,
   input  logic [7:0]                opcode,
   output logic                      win_hit,
   output logic [BANK_W-1:0]         win_phys,
   output logic                      win_write,
   output logic                      forbidden
);
   localparam int OFF_W = BUS_W - 1;

   initial begin
      if (BUS_W != 13)     $error("hsb_ctrl: BUS_W must be 13");
      if (WIN_W != BUS_W - 2) $error("hsb_ctrl: WIN_W must be BUS_W-2");
   end

   hs_op_e            op;
   logic              hs_valid;
   logic              rom_store;
   logic [ZONES*BANK_W-1:0] bank_flat;
   logic [ZONES-1:0]  mode_vec;

   assign hs_valid = acc_valid && !acc_addr[BUS_W-1];
   assign win_hit  = acc_valid && (acc_addr[BUS_W-1 -: 2] == 2'b10);

   hsb_decode #(.OFF_W(OFF_W)) u_dec (
      .hs_valid (hs_valid),
      .offset   (acc_addr[OFF_W-1:0]),
      .op       (op)
   );

   hsb_zone_file #(.ZONES(ZONES), .BANK_W(BANK_W)) u_zones (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .operand   (acc_addr[7:0]),
      .zsel      (zone_sel),
      .bank_flat (bank_flat),
      .mode_vec  (mode_vec)
   );

   hsb_window #(.ZONES(ZONES), .BANK_W(BANK_W), .WIN_W(WIN_W)) u_win (
      .win_valid (win_hit),
      .bank_flat (bank_flat),
      .mode_vec  (mode_vec),
      .zsel      (zone_sel),
      .offset    (acc_addr[WIN_W-1:0]),
      .opcode    (opcode),
      .phys      (win_phys),
      .is_write  (win_write),
      .rom_store (rom_store)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         forbidden <= 1'b0;
      else if ((op == HS_BAD) || rom_store)
         forbidden <= 1'b1;
   end
endmodule

// File: rtl/hsb_ctrl_chk.sv
module hsb_ctrl_chk #(
   parameter int ZONES  = 8,
   parameter int BANK_W = 16,
   parameter int BUS_W  = 13
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      acc_valid,
   input logic [BUS_W-1:0]          acc_addr,
   input logic [$clog2(ZONES)-1:0]  zone_sel,
   input logic [7:0]                opcode,
   input logic                      win_hit,
   input logic                      win_write,
   input logic                      forbidden,
   input logic [ZONES*BANK_W-1:0]   bank_flat,
   input logic [ZONES-1:0]          mode_vec
);
   logic [$clog2(ZONES)-1:0] zsel_d;
   logic [BANK_W-1:0] bank_now;
   logic [BANK_W-1:0] bank_d;
   logic              mode_d;

   always_ff @(posedge clk) zsel_d <= zone_sel;

   assign bank_now = bank_flat[zone_sel*BANK_W +: BANK_W];
   assign bank_d   = bank_flat[zsel_d*BANK_W +: BANK_W];
   assign mode_d   = mode_vec[zsel_d];

   // R11
   forbidden_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      forbidden |=> forbidden);

   // R10
   bad_hotspot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && ((acc_addr[12:8] == 5'h03) || (acc_addr[12:8] == 5'h0F))) |=> forbidden);

   // R2
   set_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_addr[12:8] == 5'h04) |=>
         (bank_d[7:0] == $past(acc_addr[7:0])) && (bank_d[15:8] == $past(bank_now[15:8])));

   // R5
   add_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_addr[12:8] == 5'h0C) |=>
         (bank_d == BANK_W'($past(bank_now) + BANK_W'($past(acc_addr[7:0])))));

   // R3
   mode_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_addr[12:1] == 12'h300) |=> (mode_d == $past(acc_addr[0])));

   // R8
   write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_write |-> (win_hit && opcode[7:5] == 3'b100));
endmodule

bind hsb_ctrl hsb_ctrl_chk #(.ZONES(ZONES), .BANK_W(BANK_W), .BUS_W(BUS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_addr  (acc_addr),
   .zone_sel  (zone_sel),
   .opcode    (opcode),
   .win_hit   (win_hit),
   .win_write (win_write),
   .forbidden (forbidden),
   .bank_flat (bank_flat),
   .mode_vec  (mode_vec)
);

// File: tb/hsb_ctrl_test.sv
`timescale 1ns/1ps
module hsb_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic [12:0] acc_addr = '0;
   logic [2:0]  zone_sel = '0;
   logic [7:0]  opcode = '0;
   logic        win_hit;
   logic [15:0] win_phys;
   logic        win_write;
   logic        forbidden;

   typedef struct {
      logic [15:0] phys;
      logic        wr;
      logic        forb;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   int   cycles = 0;

   always #2.5 clk = ~clk;

   hsb_ctrl uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .zone_sel  (zone_sel),
      .opcode    (opcode),
      .win_hit   (win_hit),
      .win_phys  (win_phys),
      .win_write (win_write),
      .forbidden (forbidden)
   );

   // monitor: pops one expected item per window access
   always @(negedge clk) begin
      if (rst_n && win_hit) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R7 unexpected window access phys=%h expected none", win_phys);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            if (win_phys !== e.phys || win_write !== e.wr || forbidden !== e.forb) begin
               n_fail++;
               $display("FAIL %s phys/wr/forb actual %h/%b/%b expected %h/%b/%b",
                        e.tag, win_phys, win_write, forbidden, e.phys, e.wr, e.forb);
            end
         end
      end
   end

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic raw(input logic [2:0] z, input logic [12:0] a);
      @(posedge clk); #1;
      acc_valid = 1'b1; acc_addr = a; zone_sel = z; opcode = 8'h00;
   endtask

   task automatic hot(input logic [2:0] z, input logic [11:0] off);
      raw(z, {1'b0, off});
   endtask

   task automatic probe(input logic [2:0] z, input logic [10:0] off, input logic [7:0] opc,
                        input logic [15:0] ph, input logic wr, input logic fb, input string tag);
      exp_t e;
      e.phys = ph; e.wr = wr; e.forb = fb; e.tag = tag;
      exp_q.push_back(e);
      @(posedge clk); #1;
      acc_valid = 1'b1; acc_addr = {2'b10, off}; zone_sel = z; opcode = opc;
   endtask

   task automatic idle();
      @(posedge clk); #1;
      acc_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      acc_valid = 1'b0; rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   initial begin
      do_reset();
      // R1 reset state
      probe(3'd0, 11'h000, 8'h00, 16'h0000, 1'b0, 1'b0, "R1");
      // R2 byte loads, R7 offset added
      hot(3'd2, 12'h4A5);
      hot(3'd2, 12'h512);
      probe(3'd2, 11'h010, 8'hAD, 16'h12B5, 1'b0, 1'b0, "R2");
      // R12 other zone untouched
      probe(3'd0, 11'h000, 8'hAD, 16'h0000, 1'b0, 1'b0, "R12");
      // R3 mode to RAM, R8 opcode range edges
      hot(3'd2, 12'h601);
      probe(3'd2, 11'h000, 8'h8D, 16'h12A5, 1'b1, 1'b0, "R3");
      probe(3'd2, 11'h000, 8'h80, 16'h12A5, 1'b1, 1'b0, "R8");
      probe(3'd2, 11'h000, 8'h9F, 16'h12A5, 1'b1, 1'b0, "R8");
      probe(3'd2, 11'h000, 8'hA0, 16'h12A5, 1'b0, 1'b0, "R8");
      probe(3'd2, 11'h000, 8'h7F, 16'h12A5, 1'b0, 1'b0, "R8");
      // R5 byte add/sub
      hot(3'd2, 12'hCFF);
      probe(3'd2, 11'h000, 8'hAD, 16'h13A4, 1'b0, 1'b0, "R5");
      hot(3'd2, 12'hD10);
      probe(3'd2, 11'h000, 8'hAD, 16'h1394, 1'b0, 1'b0, "R5");
      // R6 page add/sub
      hot(3'd2, 12'hE1F);
      probe(3'd2, 11'h000, 8'hAD, 16'h3294, 1'b0, 1'b0, "R6");
      hot(3'd2, 12'hE45);
      probe(3'd2, 11'h000, 8'hAD, 16'h2D94, 1'b0, 1'b0, "R6");
      // R5/R6/R7 wrap
      hot(3'd5, 12'h5FF);
      hot(3'd5, 12'h4F0);
      hot(3'd5, 12'hC20);
      probe(3'd5, 11'h000, 8'hAD, 16'h0010, 1'b0, 1'b0, "R5");
      hot(3'd5, 12'hD20);
      probe(3'd5, 11'h7FF, 8'hAD, 16'h07EF, 1'b0, 1'b0, "R7");
      hot(3'd5, 12'hE01);
      probe(3'd5, 11'h000, 8'hAD, 16'h00F0, 1'b0, 1'b0, "R6");
      // R4 page maps
      hot(3'd6, 12'h71F);
      probe(3'd6, 11'h000, 8'h8D, 16'h1F00, 1'b1, 1'b0, "R4");
      hot(3'd6, 12'h97F);
      probe(3'd6, 11'h000, 8'hAD, 16'h7F00, 1'b0, 1'b0, "R4");
      // R10 no-action areas
      hot(3'd6, 12'h2A0);
      hot(3'd6, 12'h8C0);
      raw(3'd6, 13'h0150);
      raw(3'd6, 13'h1850);
      probe(3'd6, 11'h000, 8'hAD, 16'h7F00, 1'b0, 1'b0, "R10");
      // R9 store to ROM zone
      hot(3'd2, 12'h600);
      probe(3'd2, 11'h000, 8'h8D, 16'h2D94, 1'b0, 1'b0, "R9");
      probe(3'd2, 11'h000, 8'hAD, 16'h2D94, 1'b0, 1'b1, "R9");
      // R11 sticky through a legal hot-spot
      hot(3'd2, 12'h601);
      probe(3'd2, 11'h000, 8'hAD, 16'h2D94, 1'b0, 1'b1, "R11");
      // R1 after reset
      do_reset();
      probe(3'd2, 11'h000, 8'h00, 16'h0000, 1'b0, 1'b0, "R1");
      // R10 undefined offsets
      hot(3'd1, 12'h300);
      probe(3'd1, 11'h000, 8'h00, 16'h0000, 1'b0, 1'b1, "R10");
      do_reset();
      hot(3'd3, 12'hE30);
      probe(3'd3, 11'h000, 8'h00, 16'h0000, 1'b0, 1'b1, "R10");
      do_reset();
      hot(3'd3, 12'h602);
      probe(3'd3, 11'h000, 8'h00, 16'h0000, 1'b0, 1'b1, "R10");
      idle();
      repeat (2) @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL R7 %0d window results missing, expected 0", exp_q.size());
      end
      finish_run();
   end
endmodule